// File: doc/BRIEF.md
# Pointer Masking Mode Fields

This block keeps the 2-bit pointer-masking mode fields of a 64-bit processor's control registers: one field for each privilege level whose masking can be set, plus a separate field for the hypervisor's virtual-machine loads and stores issued from user mode. Each field sits at a fixed bit position inside its control-register word. It is written and read through a plain control-register port made of an address, write data, a write enable and read data. Every write is checked against the encodings that this implementation supports. A write that asks for anything else leaves the field as it was.

The block also takes one bit per field that says the privilege mode behind that field runs with a 32-bit register width. While that bit is high the field is held at zero. For each field the block drives the decoded number of masked top address bits (0, 7 or 16) to the address path. It also raises a one-cycle request to the hypervisor for a full guest-physical fence when the guest-kernel field changes in a way that masks bits the current guest translation scheme uses.

Top module: `pm_cfg_fields`

## Requirements
- R1: The mode encoding is 2'b00 = no masking (length 0), 2'b10 = top 7 bits masked (length 7) and 2'b11 = top 16 bits masked (length 16). An accepted write sets the field's length output to the decoded value.
- R2: The fields are at these locations: machine-mode field at bits 33:32 of address 0x747, supervisor field at bits 33:32 of 0x30A, user field at bits 33:32 of 0x10A, guest-kernel field at bits 33:32 of 0x60A, and guest-user load/store field at bits 49:48 of 0x600.
- R3: A write of the reserved encoding 2'b01 leaves the field unchanged.
- R4: Each field has a 2-bit support mask, where bit 0 allows the 7-bit setting and bit 1 allows the 16-bit setting. A write of a setting the mask does not allow leaves the field unchanged. The setting 2'b00 is always accepted.
- R5: A read returns the field at its own bit position, with every other bit zero. An address that holds no field reads as zero. A write with the enable low changes nothing, and neither does a write to an address that holds no field.
- R6: xlen32 has one bit per field: bit 0 machine, bit 1 supervisor, bit 2 user, bit 3 guest-kernel, bit 4 guest-user. While a bit is high its field is cleared and writes to that field are ignored. A clear takes priority over a write in the same cycle. When the bit goes low again the old value is not restored.
- R7: With the 32-bit configuration parameter set, every field reads as zero and every length output is zero, whatever is written.
- R8: gpa_fence_req is high for exactly one cycle, the cycle after the guest-kernel field changes, when the old or the new value qualifies. A value qualifies when gstage_mode is 10 (57-bit guest scheme) and the field is nonzero, or when gstage_mode is 9 (48-bit guest scheme) and the field is 2'b11. A field that does not change raises no request.
- R9: A write takes effect at the clock edge where the enable is sampled. Length outputs and read data show the new value from that edge on, and read data follows the address combinationally.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all fields |
| csr_we | input | 1 | Write enable |
| csr_addr | input | ADDR_W (12) | Register address |
| csr_wdata | input | DW (64) | Write data |
| csr_rdata | output | DW (64) | Read data for csr_addr |
| xlen32 | input | 5 | Per-field 32-bit width indication |
| gstage_mode | input | 4 | Current guest translation scheme code |
| mlen_m | output | 5 | Masked-bit count, machine mode |
| mlen_s | output | 5 | Masked-bit count, supervisor mode |
| mlen_u | output | 5 | Masked-bit count, user mode |
| mlen_vs | output | 5 | Masked-bit count, guest kernel |
| mlen_vu | output | 5 | Masked-bit count, guest-user loads/stores |
| gpa_fence_req | output | 1 | One-cycle guest-physical fence request |

## Verification
The width clear and a software write can reach the same field in the same clock cycle. For the guest-kernel field, that same cycle can also produce a fence request. The bench raises the guest-kernel width bit in the very cycle it writes a legal nonzero setting, with the 57-bit guest scheme selected and the field already nonzero. It then requires the field to read zero, so that the clear has won, and the fence request to pulse once, because the old value qualified. A separate case holds the user width bit high across a write and then lowers it, and requires the field to stay zero.

// File: rtl/pm_cfg_pkg.sv
package pm_cfg_pkg;

   localparam int NFIELD = 5;
   localparam int LEN_W  = 5;

   // field indices, also the bit order of xlen32
   localparam int F_M  = 0;
   localparam int F_S  = 1;
   localparam int F_U  = 2;
   localparam int F_VS = 3;
   localparam int F_VU = 4;

   typedef enum logic [1:0] {
      PM_OFF   = 2'b00,
      PM_RSVD  = 2'b01,
      PM_TOP7  = 2'b10,
      PM_TOP16 = 2'b11
   } pm_mode_e;

   // guest translation scheme codes
   localparam logic [3:0] G_SV48X4 = 4'd9;
   localparam logic [3:0] G_SV57X4 = 4'd10;

   function automatic logic [LEN_W-1:0] pm_len(input logic [1:0] m);
      logic [LEN_W-1:0] r;
      case (pm_mode_e'(m))
         PM_TOP7:  r = LEN_W'(7);
         PM_TOP16: r = LEN_W'(16);
         default:  r = '0;
      endcase
      return r;
   endfunction

   function automatic logic pm_legal(input logic [1:0] m, input logic [1:0] sup);
      logic ok;
      case (pm_mode_e'(m))
         PM_OFF:   ok = 1'b1;
         PM_TOP7:  ok = sup[0];
         PM_TOP16: ok = sup[1];
         default:  ok = 1'b0;
      endcase
      return ok;
   endfunction

   // a setting that masks into the guest-physical width of the scheme
   function automatic logic pm_gpa_hit(input logic [1:0] m, input logic [3:0] g);
      logic hit;
      hit = 1'b0;
      if (g == G_SV57X4 && m != 2'b00) hit = 1'b1;
      if (g == G_SV48X4 && m == 2'b11) hit = 1'b1;
      return hit;
   endfunction

endpackage

// File: rtl/pm_mode_field.sv
module pm_mode_field
   import pm_cfg_pkg::*;
#(
   parameter logic [1:0] SUP  = 2'b11,
   parameter bit         RV32 = 1'b0
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       wr_hit,
   input  logic [1:0] wval,
   input  logic       narrow,
   output logic [1:0] mode_q,
   output logic [1:0] mode_d
);

   if (RV32) begin : g_tied
      logic unused_tied;
      assign unused_tied = ^{clk, rst_n, wr_hit, wval, narrow};
      assign mode_q = 2'b00;
      assign mode_d = 2'b00;
   end else begin : g_reg
      logic [1:0] q;

      always_comb begin
         mode_d = q;
         if (narrow) begin
            mode_d = 2'b00;
         end else if (wr_hit && pm_legal(wval, SUP)) begin
            mode_d = wval;
         end
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) q <= 2'b00;
         else        q <= mode_d;
      end

      assign mode_q = q;
   end

endmodule

// File: rtl/pm_read_mux.sv
module pm_read_mux
   import pm_cfg_pkg::*;
#(
   parameter int ADDR_W = 12,
   parameter int DW     = 64,
   parameter logic [NFIELD-1:0][ADDR_W-1:0] FADDR = '0,
   parameter logic [NFIELD-1:0][7:0]        FLSB  = '0
) (
   input  logic [ADDR_W-1:0]      addr,
   input  logic [NFIELD-1:0][1:0] fields,
   output logic [DW-1:0]          rdata
);

   always_comb begin
      rdata = '0;
      for (int i = 0; i < NFIELD; i++) begin
         if (addr == FADDR[i]) begin
            rdata[FLSB[i] +: 2] = fields[i];
         end
      end
   end

endmodule

// File: rtl/pm_fence_detect.sv
module pm_fence_detect
   import pm_cfg_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] cur,
   input  logic [1:0] nxt,
   input  logic [3:0] gmode,
   output logic       fence_req
);

   logic need;

   always_comb begin
      need = (cur != nxt) && (pm_gpa_hit(cur, gmode) || pm_gpa_hit(nxt, gmode));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) fence_req <= 1'b0;
      else        fence_req <= need;
   end

endmodule

// File: rtl/pm_cfg_fields.sv
module pm_cfg_fields
   import pm_cfg_pkg::*;
#(
   parameter int          ADDR_W     = 12,
   parameter int          DW         = 64,
   parameter bit          RV32       = 1'b0,
   parameter int          ENV_LSB    = 32,
   parameter int          HS_LSB     = 48,
   parameter logic [11:0] ADDR_MSEC  = 12'h747,
   parameter logic [11:0] ADDR_MENV  = 12'h30A,
   parameter logic [11:0] ADDR_SENV  = 12'h10A,
   parameter logic [11:0] ADDR_HENV  = 12'h60A,
   parameter logic [11:0] ADDR_HSTAT = 12'h600,
   parameter logic [1:0]  SUP_M      = 2'b11,
   parameter logic [1:0]  SUP_S      = 2'b11,
   parameter logic [1:0]  SUP_U      = 2'b11,
   parameter logic [1:0]  SUP_VS     = 2'b11,
   parameter logic [1:0]  SUP_VU     = 2'b11
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              csr_we,
   input  logic [ADDR_W-1:0] csr_addr,
   input  logic [DW-1:0]     csr_wdata,
   output logic [DW-1:0]     csr_rdata,
   input  logic [4:0]        xlen32,
   input  logic [3:0]        gstage_mode,
   output logic [4:0]        mlen_m,
   output logic [4:0]        mlen_s,
   output logic [4:0]        mlen_u,
   output logic [4:0]        mlen_vs,
   output logic [4:0]        mlen_vu,
   output logic              gpa_fence_req
);

   localparam logic [NFIELD-1:0][ADDR_W-1:0] FADDR = {
      ADDR_W'(ADDR_HSTAT), ADDR_W'(ADDR_HENV), ADDR_W'(ADDR_SENV),
      ADDR_W'(ADDR_MENV),  ADDR_W'(ADDR_MSEC)};
   localparam logic [NFIELD-1:0][7:0] FLSB = {
      8'(HS_LSB), 8'(ENV_LSB), 8'(ENV_LSB), 8'(ENV_LSB), 8'(ENV_LSB)};
   localparam logic [NFIELD-1:0][1:0] FSUP = {SUP_VU, SUP_VS, SUP_U, SUP_S, SUP_M};

   if (ENV_LSB + 2 > DW || HS_LSB + 2 > DW) begin : g_bad_lsb
      $error("pm_cfg_fields: a field does not fit in the data word");
   end
   if (ADDR_W < 1 || ADDR_W > 12) begin : g_bad_addr
      $error("pm_cfg_fields: ADDR_W out of range");
   end
   if (ENV_LSB == HS_LSB && ADDR_HENV == ADDR_HSTAT) begin : g_bad_overlap
      $error("pm_cfg_fields: two fields overlap");
   end

   logic [NFIELD-1:0][1:0] f_q;
   logic [NFIELD-1:0][1:0] f_d;
   logic [NFIELD-1:0][LEN_W-1:0] f_len;

   for (genvar g = 0; g < NFIELD; g++) begin : g_field
      logic hit;
      assign hit = csr_we && (csr_addr == FADDR[g]);

      pm_mode_field #(
         .SUP  (FSUP[g]),
         .RV32 (RV32)
      ) u_field (
         .clk    (clk),
         .rst_n  (rst_n),
         .wr_hit (hit),
         .wval   (csr_wdata[FLSB[g] +: 2]),
         .narrow (xlen32[g]),
         .mode_q (f_q[g]),
         .mode_d (f_d[g])
      );

      assign f_len[g] = pm_len(f_q[g]);
   end

   logic unused_wdata;
   assign unused_wdata = ^{csr_wdata, f_d[F_M], f_d[F_S], f_d[F_U], f_d[F_VU]};

   pm_read_mux #(
      .ADDR_W (ADDR_W),
      .DW     (DW),
      .FADDR  (FADDR),
      .FLSB   (FLSB)
   ) u_rd (
      .addr   (csr_addr),
      .fields (f_q),
      .rdata  (csr_rdata)
   );

   pm_fence_detect u_fence (
      .clk       (clk),
      .rst_n     (rst_n),
      .cur       (f_q[F_VS]),
      .nxt       (f_d[F_VS]),
      .gmode     (gstage_mode),
      .fence_req (gpa_fence_req)
   );

   assign mlen_m  = f_len[F_M];
   assign mlen_s  = f_len[F_S];
   assign mlen_u  = f_len[F_U];
   assign mlen_vs = f_len[F_VS];
   assign mlen_vu = f_len[F_VU];

endmodule

// File: rtl/pm_cfg_fields_chk.sv
module pm_cfg_fields_chk #(
   parameter int          ADDR_W    = 12,
   parameter int          DW        = 64,
   parameter int          ENV_LSB   = 32,
   parameter logic [11:0] ADDR_MENV = 12'h30A
) (
   input logic              clk,
   input logic              rst_n,
   input logic              csr_we,
   input logic [ADDR_W-1:0] csr_addr,
   input logic [DW-1:0]     csr_wdata,
   input logic [4:0]        xlen32,
   input logic [4:0]        mlen_s,
   input logic [4:0]        mlen_u,
   input logic [4:0]        mlen_vs,
   input logic              gpa_fence_req
);

   // R1: only the three defined lengths ever appear
   a_r1_len_set: assert property (@(posedge clk) disable iff (!rst_n)
      (mlen_s == 5'd0 || mlen_s == 5'd7 || mlen_s == 5'd16) &&
      (mlen_vs == 5'd0 || mlen_vs == 5'd7 || mlen_vs == 5'd16));

   // R3: reserved encoding written to the supervisor field changes nothing
   a_r3_rsvd_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (csr_we && csr_addr == ADDR_W'(ADDR_MENV) &&
       csr_wdata[ENV_LSB +: 2] == 2'b01 && !xlen32[1]) |=> $stable(mlen_s));

   // R5: no write and no clear leaves the lengths unchanged
   a_r5_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
      (!csr_we && xlen32 == 5'b0) |=> ($stable(mlen_s) && $stable(mlen_u) && $stable(mlen_vs)));

   // R6: a narrow width bit forces the field to zero on the next cycle
   a_r6_narrow_clear: assert property (@(posedge clk) disable iff (!rst_n)
      xlen32[2] |=> (mlen_u == 5'd0));

   // R8: a fence request only accompanies a change of the guest-kernel field
   a_r8_fence_on_change: assert property (@(posedge clk) disable iff (!rst_n)
      gpa_fence_req |-> (mlen_vs != $past(mlen_vs)));

endmodule

bind pm_cfg_fields pm_cfg_fields_chk #(
   .ADDR_W    (ADDR_W),
   .DW        (DW),
   .ENV_LSB   (ENV_LSB),
   .ADDR_MENV (ADDR_MENV)
) u_chk (
   .clk           (clk),
   .rst_n         (rst_n),
   .csr_we        (csr_we),
   .csr_addr      (csr_addr),
   .csr_wdata     (csr_wdata),
   .xlen32        (xlen32),
   .mlen_s        (mlen_s),
   .mlen_u        (mlen_u),
   .mlen_vs       (mlen_vs),
   .gpa_fence_req (gpa_fence_req)
);

// File: tb/pm_cfg_fields_bench.sv
module pm_cfg_fields_bench;

   localparam time CYC = 20ns;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        csr_we = 1'b0;
   logic [11:0] csr_addr = '0;
   logic [63:0] csr_wdata = '0;
   logic [4:0]  xlen32 = '0;
   logic [3:0]  gstage_mode = '0;
   logic [63:0] csr_rdata, rdata32;
   logic [4:0]  mlen_m, mlen_s, mlen_u, mlen_vs, mlen_vu;
   logic [4:0]  l32_m, l32_s, l32_u, l32_vs, l32_vu;
   logic        gpa_fence_req, fence32;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #(CYC/2) clk = ~clk;

   pm_cfg_fields #(.SUP_M(2'b10), .SUP_VU(2'b01)) u_pm_cfg_fields (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .xlen32(xlen32),
      .gstage_mode(gstage_mode), .mlen_m(mlen_m), .mlen_s(mlen_s),
      .mlen_u(mlen_u), .mlen_vs(mlen_vs), .mlen_vu(mlen_vu),
      .gpa_fence_req(gpa_fence_req));

   pm_cfg_fields #(.RV32(1'b1)) u_pm_cfg_fields_rv32 (
      .clk(clk), .rst_n(rst_n), .csr_we(csr_we), .csr_addr(csr_addr),
      .csr_wdata(csr_wdata), .csr_rdata(rdata32), .xlen32(xlen32),
      .gstage_mode(gstage_mode), .mlen_m(l32_m), .mlen_s(l32_s),
      .mlen_u(l32_u), .mlen_vs(l32_vs), .mlen_vu(l32_vu),
      .gpa_fence_req(fence32));

   function automatic logic [11:0] addr_of(input int idx);
      case (idx)
         0: return 12'h747;
         1: return 12'h30A;
         2: return 12'h10A;
         3: return 12'h60A;
         default: return 12'h600;
      endcase
   endfunction

   function automatic int lsb_of(input int idx);
      return (idx == 4) ? 48 : 32;
   endfunction

   function automatic logic [4:0] len_of(input int idx);
      case (idx)
         0: return mlen_m;
         1: return mlen_s;
         2: return mlen_u;
         3: return mlen_vs;
         default: return mlen_vu;
      endcase
   endfunction

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // write one field value; returns one negedge after the capturing edge
   task automatic wr(input logic [11:0] a, input logic [63:0] d);
      @(negedge clk);
      csr_addr = a; csr_wdata = d; csr_we = 1'b1;
      @(negedge clk);
      csr_we = 1'b0;
   endtask

   typedef struct packed {
      logic [2:0] idx;
      logic [1:0] val;
      logic [4:0] exp;
      logic [3:0] rq;
   } vec_t;

   // main instance: machine field allows only 16, guest-user only 7
   localparam vec_t VEC [12] = '{
      '{3'd1, 2'b10, 5'd7,  4'd1},
      '{3'd1, 2'b11, 5'd16, 4'd1},
      '{3'd1, 2'b01, 5'd16, 4'd3},
      '{3'd1, 2'b00, 5'd0,  4'd1},
      '{3'd0, 2'b10, 5'd0,  4'd4},
      '{3'd0, 2'b11, 5'd16, 4'd2},
      '{3'd0, 2'b10, 5'd16, 4'd4},
      '{3'd2, 2'b11, 5'd16, 4'd2},
      '{3'd4, 2'b11, 5'd0,  4'd4},
      '{3'd4, 2'b10, 5'd7,  4'd2},
      '{3'd3, 2'b10, 5'd7,  4'd2},
      '{3'd3, 2'b01, 5'd7,  4'd3}};

   initial begin
      #(CYC * 20000);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog actual=hung expected=done");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // reset state
      for (int i = 0; i < 5; i++) begin
         csr_addr = addr_of(i);
         #1;
         check("R9 reset rdata", csr_rdata, 64'h0);
         check("R9 reset len", 64'(len_of(i)), 64'h0);
      end
      check("R8 reset fence", 64'(gpa_fence_req), 64'h0);

      // R1 R2 R3 R4 table walk; R7 the 32-bit instance stays zero
      for (int k = 0; k < 12; k++) begin
         int ix;
         ix = int'(VEC[k].idx);
         wr(addr_of(ix), 64'(VEC[k].val) << lsb_of(ix));
         check($sformatf("R%0d len vec %0d", VEC[k].rq, k), 64'(len_of(ix)), 64'(VEC[k].exp));
         check($sformatf("R%0d rdata vec %0d", VEC[k].rq, k), csr_rdata,
               64'((VEC[k].exp == 5'd16) ? 2'b11 : (VEC[k].exp == 5'd7) ? 2'b10 : 2'b00) << lsb_of(ix));
         check("R7 rv32 rdata", rdata32, 64'h0);
         check("R7 rv32 len", 64'({l32_m, l32_s, l32_u, l32_vs, l32_vu}), 64'h0);
      end

      // R5 enable low: machine field stays 16
      @(negedge clk);
      csr_addr = 12'h747; csr_wdata = 64'h0; csr_we = 1'b0;
      @(negedge clk);
      check("R5 no enable", 64'(mlen_m), 64'd16);
      // R5 unmapped address
      wr(12'h7C0, '1);
      check("R5 unmapped rdata", csr_rdata, 64'h0);
      check("R5 unmapped no effect", 64'({mlen_m, mlen_s, mlen_u, mlen_vs, mlen_vu}),
            64'({5'd16, 5'd0, 5'd16, 5'd7, 5'd7}));
      // R5 in place with all other bits zero
      wr(12'h30A, '1);
      check("R5 in place supervisor", csr_rdata, 64'h0000_0003_0000_0000);
      wr(12'h600, '1);
      check("R5 R4 in place guest-user", csr_rdata, 64'h0002_0000_0000_0000);

      // R6 width clear on user field
      @(negedge clk);
      xlen32[2] = 1'b1;
      @(negedge clk);
      check("R6 cleared", 64'(mlen_u), 64'd0);
      wr(12'h10A, 64'h2 << 32);
      check("R6 write ignored while narrow", 64'(mlen_u), 64'd0);
      xlen32[2] = 1'b0;
      @(negedge clk);
      @(negedge clk);
      check("R6 not restored", 64'(mlen_u), 64'd0);

      // R8 fence cases, guest-kernel field starts at 7
      gstage_mode = 4'd10;
      wr(12'h60A, 64'h0);
      check("R8 7->0 sv57", 64'(gpa_fence_req), 64'd1);
      @(negedge clk);
      check("R8 single cycle", 64'(gpa_fence_req), 64'd0);
      wr(12'h60A, 64'h2 << 32);
      check("R8 0->7 sv57", 64'(gpa_fence_req), 64'd1);
      gstage_mode = 4'd9;
      wr(12'h60A, 64'h3 << 32);
      check("R8 7->16 sv48", 64'(gpa_fence_req), 64'd1);
      wr(12'h60A, 64'h3 << 32);
      check("R8 no change", 64'(gpa_fence_req), 64'd0);
      wr(12'h60A, 64'h2 << 32);
      check("R8 16->7 sv48", 64'(gpa_fence_req), 64'd1);
      wr(12'h60A, 64'h0);
      check("R8 7->0 sv48", 64'(gpa_fence_req), 64'd0);
      gstage_mode = 4'd8;
      wr(12'h60A, 64'h3 << 32);
      check("R8 0->16 sv39", 64'(gpa_fence_req), 64'd0);
      check("R8 field 16", 64'(mlen_vs), 64'd16);

      // R6 R8 clear and write in the same cycle
      gstage_mode = 4'd10;
      @(negedge clk);
      xlen32[3] = 1'b1;
      csr_addr = 12'h60A; csr_wdata = 64'h2 << 32; csr_we = 1'b1;
      @(negedge clk);
      csr_we = 1'b0;
      check("R6 clear beats write", 64'(mlen_vs), 64'd0);
      check("R8 fence from clear", 64'(gpa_fence_req), 64'd1);
      @(negedge clk);
      check("R8 held clear no fence", 64'(gpa_fence_req), 64'd0);
      xlen32[3] = 1'b0;
      @(negedge clk);
      check("R9 guest-kernel rdata", csr_rdata, 64'h0);

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule